// File: doc/BRIEF.md
# DMA Completion Interrupt Register

This block sits beside a DMA engine and turns the engine's "transfer finished" indication into an interrupt request with a priority. Software programs a 3-bit priority level and an enable flag through a simple register port. When the DMA engine asserts its done signal while the enable is set, a pending flag is latched. While that flag is set, the block raises an interrupt request that carries the programmed level.

The pending flag is edge-triggered. It is set only when the combined condition (enable AND done) goes from low to high. Software clears the flag by writing a one to its bit; writing a zero to that bit does nothing. Turning the enable off also clears it. After a clear, a done signal that stays high does not set the flag again. Only a new rising edge of the combined condition sets it. If a clear and a new edge fall in the same cycle, the edge wins. An optional synchroniser on the done input is chosen by a parameter. With the default of zero stages, the done input is used directly.

Top module: `dmairq_ctrl`

## Requirements
- R1: While reset is asserted (active low, asynchronous), the level, enable and pending bits are zero, so `rd_data`, `irq_req` and `irq_level` all read zero.
- R2: A write stores `wr_data[2:0]` as the level and `wr_data[3]` as the enable. These appear on `rd_data[2:0]` and `rd_data[3]` after the next clock edge. `rd_data[7]` shows the pending bit.
- R3: Bits 6 to 4 of `rd_data` always read zero, and writes to those bits have no effect.
- R4: Pending becomes 1 at the first clock edge where enable AND `dma_done` is high, provided that condition was low at the previous edge.
- R5: A write with `wr_data[7]=1` clears pending at that clock edge. A write with `wr_data[7]=0` leaves pending unchanged.
- R6: If the stored enable is 0 during a cycle, pending is 0 after that cycle's clock edge.
- R7: Pending holds its value when there is no edge, no clear and no disable. Once pending is cleared, it stays clear while enable AND `dma_done` remains high.
- R8: `irq_req` is 1 exactly when pending is 1 and the level is nonzero. In that case `irq_level` equals the stored level, and it follows later level writes. Otherwise `irq_level` is 0.
- R9: When a write-one clear and a new rising edge of enable AND done occur in the same cycle, pending is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data: [2:0] level, [3] enable, [7] write 1 to clear pending |
| rd_data | output | 8 | Readback: [2:0] level, [3] enable, [6:4] zero, [7] pending |
| dma_done | input | 1 | Transfer-complete indication from the DMA engine |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority carried by the request, zero when idle |

## Verification
Each property is written for the default configuration with no done synchroniser, so `dma_done` acts on pending in the same cycle it is sampled. The write-clear property only fires when `dma_done` is low, so no rising edge can compete with the clear. The rising-edge property depends on the enable and done being stable at the sampling edge. The bench meets this by changing `wr_en`, `wr_data` and `dma_done` only at falling edges, giving each write exactly one cycle, and holding done steady across the cycles where it is tested as a level.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
   // Next-state decision for the pending flag, in priority order.
   typedef enum logic [1:0] {
      PEND_HOLD = 2'd0,
      PEND_SET  = 2'd1,
      PEND_CLR  = 2'd2
   } pend_op_e;

   function automatic pend_op_e pend_decide(input logic rise,
                                            input logic en,
                                            input logic w1c);
      if (rise)
         return PEND_SET;
      else if (!en || w1c)
         return PEND_CLR;
      else
         return PEND_HOLD;
   endfunction
endpackage

// File: rtl/dmairq_done_sync.sv
module dmairq_done_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("dmairq_done_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
   end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sr_q <= '0;
         else if (STAGES == 1)
            sr_q[0] <= d_in;
         else
            sr_q <= {sr_q[STAGES-2:0], d_in};
      end
      assign d_out = sr_q[STAGES-1];
   end
endmodule

// File: rtl/dmairq_cfg_reg.sv
module dmairq_cfg_reg #(
   parameter int DATA_W  = 8,
   parameter int LEVEL_W = 3,
   parameter int EN_POS  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [LEVEL_W-1:0] level,
   output logic               enable
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level  <= '0;
         enable <= 1'b0;
      end else if (wr_en) begin
         level  <= wr_data[LEVEL_W-1:0];
         enable <= wr_data[EN_POS];
      end
   end
endmodule

// File: rtl/dmairq_pend_flag.sv
module dmairq_pend_flag
   import dmairq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic done,
   input  logic w1c,
   output logic pend
);
   logic     cond;
   logic     cond_q;
   logic     rise;
   pend_op_e op;

   assign cond = enable & done;
   assign rise = cond & ~cond_q;
   assign op   = pend_decide(rise, enable, w1c);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         pend   <= 1'b0;
      end else begin
         cond_q <= cond;
         case (op)
            PEND_SET: pend <= 1'b1;
            PEND_CLR: pend <= 1'b0;
            default:  pend <= pend;
         endcase
      end
   end
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl #(
   parameter int DATA_W    = 8,
   parameter int LEVEL_W   = 3,
   parameter int EN_POS    = 3,
   parameter int PEND_POS  = 7,
   parameter int DONE_SYNC = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               dma_done,
   output logic               irq_req,
   output logic [LEVEL_W-1:0] irq_level
);
   localparam int GAP_LO = EN_POS + 1;

   if (LEVEL_W < 1 || LEVEL_W > EN_POS) begin : g_bad_level
      $error("dmairq_ctrl: level field must fit below the enable bit");
   end
   if (PEND_POS <= EN_POS || PEND_POS >= DATA_W) begin : g_bad_pend
      $error("dmairq_ctrl: pending bit must sit above enable inside the word");
   end

   logic [LEVEL_W-1:0] level;
   logic               enable;
   logic               done_s;
   logic               pend;

   dmairq_cfg_reg #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .EN_POS(EN_POS)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .level(level), .enable(enable)
   );

   dmairq_done_sync #(.STAGES(DONE_SYNC)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_in(dma_done), .d_out(done_s)
   );

   dmairq_pend_flag i_pend (
      .clk(clk), .rst_n(rst_n), .enable(enable), .done(done_s),
      .w1c(wr_en & wr_data[PEND_POS]), .pend(pend)
   );

   always_comb begin
      rd_data                  = '0;
      rd_data[LEVEL_W-1:0]     = level;
      rd_data[EN_POS]          = enable;
      rd_data[PEND_POS]        = pend;
   end

   assign irq_req   = pend & (level != '0);
   assign irq_level = irq_req ? level : '0;
endmodule

// File: rtl/dmairq_ctrl_chk.sv
module dmairq_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       dma_done,
   input logic       irq_req,
   input logic [2:0] irq_level
);
   assert_reset_zero_R1: assert property (@(posedge clk)
      !rst_n |-> (rd_data == 8'h00 && !irq_req && irq_level == 3'd0));

   assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[3:0] == $past(wr_data[3:0]));

   assert_gap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[6:4] == 3'b000);

   assert_set_needs_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[7]) |-> $past(dma_done && rd_data[3]));

   assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[7] && !dma_done) |=> !rd_data[7]);

   assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[3] |=> !rd_data[7]);

   assert_req_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_level == rd_data[2:0] && irq_level != 3'd0 && rd_data[7]));

   assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> irq_level == 3'd0);
endmodule

bind dmairq_ctrl dmairq_ctrl_chk i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .dma_done(dma_done), .irq_req(irq_req),
   .irq_level(irq_level)
);

// File: tb/test_dmairq_ctrl.sv
module test_dmairq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       dma_done = 1'b0;
   logic [7:0] rd_data;
   logic       irq_req;
   logic [2:0] irq_level;
   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   dmairq_ctrl i_dmairq_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .dma_done(dma_done), .irq_req(irq_req),
      .irq_level(irq_level)
   );

   // {req, wr_en, wr_data, dma_done, exp_rd, exp_req, exp_lvl}
   localparam logic [25:0] VEC [0:16] = '{
      {4'd2, 1'b1, 8'h0D, 1'b0, 8'h0D, 1'b0, 3'd0}, // R2 enable, level 5
      {4'd4, 1'b0, 8'h00, 1'b1, 8'h8D, 1'b1, 3'd5}, // R4 done rises
      {4'd7, 1'b0, 8'h00, 1'b1, 8'h8D, 1'b1, 3'd5}, // R7 hold
      {4'd5, 1'b1, 8'h8D, 1'b1, 8'h0D, 1'b0, 3'd0}, // R5 write one clears
      {4'd7, 1'b0, 8'h00, 1'b1, 8'h0D, 1'b0, 3'd0}, // R7 stays clear, done high
      {4'd7, 1'b0, 8'h00, 1'b0, 8'h0D, 1'b0, 3'd0}, // R7 done drops
      {4'd4, 1'b0, 8'h00, 1'b1, 8'h8D, 1'b1, 3'd5}, // R4 new edge
      {4'd5, 1'b1, 8'h0D, 1'b1, 8'h8D, 1'b1, 3'd5}, // R5 write zero ignored
      {4'd8, 1'b1, 8'h0A, 1'b1, 8'h8A, 1'b1, 3'd2}, // R8 level follows
      {4'd6, 1'b1, 8'h02, 1'b1, 8'h82, 1'b1, 3'd2}, // R6 disable written
      {4'd6, 1'b0, 8'h00, 1'b1, 8'h02, 1'b0, 3'd0}, // R6 pending cleared
      {4'd2, 1'b1, 8'h08, 1'b1, 8'h08, 1'b0, 3'd0}, // R2 re-enable, level 0
      {4'd8, 1'b0, 8'h00, 1'b1, 8'h88, 1'b0, 3'd0}, // R8 level 0, no request
      {4'd3, 1'b1, 8'h7F, 1'b1, 8'h8F, 1'b1, 3'd7}, // R3 gap bits ignored
      {4'd7, 1'b0, 8'h00, 1'b0, 8'h8F, 1'b1, 3'd7}, // R7 pending holds
      {4'd9, 1'b1, 8'h8F, 1'b1, 8'h8F, 1'b1, 3'd7}, // R9 set beats clear
      {4'd5, 1'b1, 8'h8F, 1'b1, 8'h0F, 1'b0, 3'd0}  // R5 clear with done held
   };

   task automatic check(input int req, input logic [7:0] e_rd,
                        input logic e_req, input logic [2:0] e_lvl);
      n_chk++;
      if (rd_data !== e_rd || irq_req !== e_req || irq_level !== e_lvl) begin
         n_bad++;
         $display("FAIL R%0d: rd=%h req=%b lvl=%0d expected rd=%h req=%b lvl=%0d",
                  req, rd_data, irq_req, irq_level, e_rd, e_req, e_lvl);
      end
   endtask

   task automatic drive(input logic w, input logic [7:0] d, input logic dn);
      wr_en = w; wr_data = d; dma_done = dn;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(1, 8'h00, 1'b0, 3'd0); // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 17; i++) begin
         drive(VEC[i][21], VEC[i][20:13], VEC[i][12]);
         check(int'(VEC[i][25:22]), VEC[i][11:4], VEC[i][3], VEC[i][2:0]);
      end
      // R1 reset in the middle of operation, pending set beforehand
      drive(1'b0, 8'h00, 1'b0);
      drive(1'b0, 8'h00, 1'b1);
      check(4, 8'h8F, 1'b1, 3'd7); // R4 set again before reset
      rst_n = 1'b0;
      #1;
      check(1, 8'h00, 1'b0, 3'd0); // R1 async clear
      @(negedge clk);
      rst_n = 1'b1;
      // R4 done already high when enable is written
      drive(1'b1, 8'h0B, 1'b1);
      check(2, 8'h0B, 1'b0, 3'd0); // R2 stored, not yet pending
      drive(1'b0, 8'h00, 1'b1);
      check(4, 8'h8B, 1'b1, 3'd3); // R4 edge from enable
      drive(1'b0, 8'h00, 1'b0);
      check(3, 8'h8B, 1'b1, 3'd3); // R3 gap still zero
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule